// File: doc/BRIEF.md
# T=0 Smart Card Character Receiver

This block receives characters from a smart card over the single shared, idle-high I/O line, using the asynchronous character framing of the ISO 7816 T=0 protocol. A tick enable oversamples the line at `TICKS_PER_ETU` ticks per elementary time unit (ETU). A falling edge seen on an idle line starts a frame. The start bit is confirmed at its midpoint. Eight data bits follow, least significant first, then a parity bit. Each bit is sampled near the middle of its ETU.

Each character is checked for even parity. A failing character sets a one-cycle error flag and a sticky status bit. Depending on configuration, a failing character can also be dropped, or signalled to the card. To signal it, the receiver pulls the line low during the guard time, which asks the card to repeat the character. A test input makes every character count as a parity failure, so the error paths can be exercised. The same rules apply to every character, including the first character of the answer to reset.

Control flow is one state machine:
- IDLE: the line is watched for a falling edge (transition *detect*).
- START: the start bit is checked at mid-ETU. *Confirm* moves on to DATA. A high level is a *false start* and returns to IDLE.
- DATA: eight samples are taken. The *last data bit* moves on to PARITY.
- PARITY: the verdict is made and the outputs are raised (*judge*), then WAIT.
- WAIT: the machine holds until 10.5 ETU after the start edge. It then moves to SIGNAL if an error pulse is due (*signal*), or to IDLE (*done*).
- SIGNAL: the line is driven low for 1 or 2 ETU, then the machine moves to RECOVER (*release*).
- RECOVER: the machine waits for a high sample, then returns to IDLE (*rearm*).

Top module: `t0_char_rx`

## Requirements
- R1: A frame is one low start bit, then eight data bits sent least significant bit first (a high line level is a 1), then one parity bit. Each bit is sampled near mid-ETU. For a character with correct parity, `rx_valid` pulses for one cycle with the byte on `rx_data`, and `rx_perr` stays low.
- R2: While `cfg_chk_off` is 0, a character is a parity failure when the number of ones across its eight data bits and its parity bit is odd. `rx_perr` then pulses for one cycle, in the same cycle in which `rx_valid` would pulse.
- R3: While `cfg_chk_off` is 1, no character raises `rx_perr`, no error pulse is driven, and every character is delivered with `rx_valid`.
- R4: When a character fails parity while `cfg_sig_en` and `cfg_t0` are both 1, `line_drive_low` goes high about 10.5 ETU after the start edge. It stays high for `TICKS_PER_ETU` ticks when `cfg_long_pulse` is 0, and for twice that when it is 1. It is then released.
- R5: No error pulse is driven when `cfg_sig_en` is 0, when `cfg_t0` is 0, or when the character passes parity.
- R6: When `cfg_drop_en` is 1, a character that fails parity gets no `rx_valid` pulse. When `cfg_drop_en` is 0, a failing character is still delivered.
- R7: While `cfg_force_err` is 1 and checking is enabled, every character is treated as a parity failure, whatever its parity bit.
- R8: `perr_sticky` is set by any parity failure and stays set until `clr_err` is pulsed. A failure in the same cycle as the clear wins.
- R9: A low level on the line that has gone high again by the start bit's midpoint is ignored. It produces no output and no pulse.
- R10: After reset, `line_drive_low`, `rx_valid`, `rx_perr` and `perr_sticky` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Oversampling enable, `TICKS_PER_ETU` per ETU |
| line_in | input | 1 | Level of the shared I/O line |
| cfg_chk_off | input | 1 | 1 disables parity checking |
| cfg_sig_en | input | 1 | 1 enables the error pulse to the card |
| cfg_t0 | input | 1 | 1 selects T=0 character mode |
| cfg_drop_en | input | 1 | 1 drops characters that fail parity |
| cfg_force_err | input | 1 | Test: every character fails parity |
| cfg_long_pulse | input | 1 | Error pulse length: 0 gives 1 ETU, 1 gives 2 ETU |
| clr_err | input | 1 | Clears `perr_sticky` |
| line_drive_low | output | 1 | 1 pulls the shared line low |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | One-cycle strobe for a delivered byte |
| rx_perr | output | 1 | One-cycle parity-failure flag |
| perr_sticky | output | 1 | Sticky parity-failure status |

## Verification
The bench plays the card as an open-drain driver on the line. It sends bytes with correct parity and with inverted parity. A data mismatch shows a bit-order or sampling fault. A flag mismatch shows a fault in the parity sum.

Each flag is then combined with every switch. Checking off tells apart an error that is only hidden from one that is also dropped or signalled. Drop, signal and T=0 mode are tried one at a time, and the force-error test is run on good characters. The pulse is measured both for where it starts and for how long it lasts, so the 1-ETU and 2-ETU settings are told apart.

A short low glitch shows whether false starts are rejected. Random characters with random settings are checked against a bench model, and the model also covers the sticky flag and its clear.

// File: rtl/t0rx_pkg.sv
package t0rx_pkg;
    typedef enum logic [2:0] {
        S_IDLE    = 3'd0,
        S_START   = 3'd1,
        S_DATA    = 3'd2,
        S_PARITY  = 3'd3,
        S_WAIT    = 3'd4,
        S_SIGNAL  = 3'd5,
        S_RECOVER = 3'd6
    } rx_state_t;

    localparam int unsigned DATA_BITS   = 8;
    localparam int unsigned PAR_SLOT    = DATA_BITS + 1;
    localparam int unsigned SIG_SLOT    = DATA_BITS + 2;
    localparam int unsigned SLOT_W      = 4;
endpackage

// File: rtl/t0rx_sync.sv
module t0rx_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic d_out
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '1;
                else        chain <= d_in;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-2:0], d_in};
            end
        end
    endgenerate

    assign d_out = chain[STAGES-1];
endmodule

// File: rtl/t0rx_etu_timer.sv
module t0rx_etu_timer #(
    parameter int unsigned TICKS_PER_ETU = 16,
    parameter int unsigned SLOT_W        = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              run,
    input  logic              tick,
    output logic              mid,
    output logic [SLOT_W-1:0] slot
);
    localparam int unsigned PH_W = (TICKS_PER_ETU > 1) ? $clog2(TICKS_PER_ETU) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(TICKS_PER_ETU - 1);
    localparam logic [PH_W-1:0] PH_HALF = PH_W'(TICKS_PER_ETU / 2);

    logic [PH_W-1:0] phase;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= '0;
            slot  <= '0;
        end else if (clr) begin
            phase <= '0;
            slot  <= '0;
        end else if (run && tick) begin
            if (phase == PH_LAST) begin
                phase <= '0;
                if (slot != '1) slot <= slot + 1'b1;
            end else begin
                phase <= phase + 1'b1;
            end
        end
    end

    assign mid = run && tick && (phase == PH_HALF);
endmodule

// File: rtl/t0rx_shift.sv
module t0rx_shift #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             shift_en,
    input  logic             bit_in,
    output logic [WIDTH-1:0] data,
    output logic             ones_odd
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data     <= '0;
            ones_odd <= 1'b0;
        end else if (clr) begin
            data     <= '0;
            ones_odd <= 1'b0;
        end else if (shift_en) begin
            data     <= {bit_in, data[WIDTH-1:1]};
            ones_odd <= ones_odd ^ bit_in;
        end
    end
endmodule

// File: rtl/t0_char_rx.sv
module t0_char_rx #(
    parameter int unsigned TICKS_PER_ETU = 16,
    parameter int unsigned SYNC_STAGES   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       line_in,
    input  logic       cfg_chk_off,
    input  logic       cfg_sig_en,
    input  logic       cfg_t0,
    input  logic       cfg_drop_en,
    input  logic       cfg_force_err,
    input  logic       cfg_long_pulse,
    input  logic       clr_err,
    output logic       line_drive_low,
    output logic [7:0] rx_data,
    output logic       rx_valid,
    output logic       rx_perr,
    output logic       perr_sticky
);
    import t0rx_pkg::*;

    localparam logic [SLOT_W-1:0] LAST_DATA = SLOT_W'(DATA_BITS);
    localparam logic [SLOT_W-1:0] SIG_AT    = SLOT_W'(SIG_SLOT);
    localparam logic [SLOT_W-1:0] END_SHORT = SLOT_W'(SIG_SLOT + 1);
    localparam logic [SLOT_W-1:0] END_LONG  = SLOT_W'(SIG_SLOT + 2);

    rx_state_t state, state_nx;

    logic line_s;
    logic line_prev;
    logic mid;
    logic [SLOT_W-1:0] slot;
    logic [DATA_BITS-1:0] shift_data;
    logic ones_odd;
    logic start_det;
    logic shift_en;
    logic judge;
    logic perr_now;
    logic sig_pending;
    logic long_q;

    t0rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (line_in),
        .d_out (line_s)
    );

    t0rx_etu_timer #(.TICKS_PER_ETU(TICKS_PER_ETU), .SLOT_W(SLOT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start_det),
        .run   (state != S_IDLE),
        .tick  (tick),
        .mid   (mid),
        .slot  (slot)
    );

    t0rx_shift #(.WIDTH(DATA_BITS)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (start_det),
        .shift_en (shift_en),
        .bit_in   (line_s),
        .data     (shift_data),
        .ones_odd (ones_odd)
    );

    assign start_det = (state == S_IDLE) && tick && line_prev && !line_s;
    assign shift_en  = (state == S_DATA) && mid;
    assign judge     = (state == S_PARITY) && mid;
    assign perr_now  = !cfg_chk_off && ((ones_odd ^ line_s) || cfg_force_err);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:    if (start_det) state_nx = S_START;
            S_START:   if (mid) state_nx = line_s ? S_IDLE : S_DATA;
            S_DATA:    if (mid && slot == LAST_DATA) state_nx = S_PARITY;
            S_PARITY:  if (mid) state_nx = S_WAIT;
            S_WAIT:    if (mid && slot == SIG_AT)
                           state_nx = sig_pending ? S_SIGNAL : S_IDLE;
            S_SIGNAL:  if (mid && slot == (long_q ? END_LONG : END_SHORT))
                           state_nx = S_RECOVER;
            S_RECOVER: if (tick && line_s) state_nx = S_IDLE;
            default:   state_nx = S_IDLE;
        endcase
    end

    // registered outputs and per-character decisions
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data     <= '0;
            rx_valid    <= 1'b0;
            rx_perr     <= 1'b0;
            perr_sticky <= 1'b0;
            sig_pending <= 1'b0;
            long_q      <= 1'b0;
            line_prev   <= 1'b0;
        end else begin
            if (tick) line_prev <= line_s;
            rx_valid <= judge && !(perr_now && cfg_drop_en);
            rx_perr  <= judge && perr_now;
            if (judge) begin
                rx_data     <= shift_data;
                sig_pending <= perr_now && cfg_sig_en && cfg_t0;
                long_q      <= cfg_long_pulse;
            end
            if (judge && perr_now)  perr_sticky <= 1'b1;
            else if (clr_err)       perr_sticky <= 1'b0;
        end
    end

    assign line_drive_low = (state == S_SIGNAL);
endmodule

// File: rtl/t0rx_checker.sv
module t0rx_checker #(
    parameter int unsigned TICKS_PER_ETU = 16
) (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic cfg_chk_off,
    input logic cfg_sig_en,
    input logic cfg_t0,
    input logic cfg_drop_en,
    input logic clr_err,
    input logic line_drive_low,
    input logic rx_valid,
    input logic rx_perr,
    input logic perr_sticky
);
    localparam int unsigned MAX_LOW = 2 * TICKS_PER_ETU;
    localparam int unsigned CW = $clog2(MAX_LOW + 2) + 1;

    logic [CW-1:0] low_ticks;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              low_ticks <= '0;
        else if (!line_drive_low) low_ticks <= '0;
        else if (tick)           low_ticks <= low_ticks + 1'b1;
    end

    assert_no_perr_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_perr |-> !cfg_chk_off);

    assert_drop_blocks_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_perr && cfg_drop_en) |-> !rx_valid);

    assert_sticky_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_perr |=> perr_sticky);

    assert_sticky_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_err && !rx_perr) |=> !perr_sticky);

    assert_pulse_needs_enables_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_drive_low) |-> (cfg_sig_en && cfg_t0 && !cfg_chk_off));

    assert_pulse_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
        line_drive_low |-> (low_ticks <= CW'(MAX_LOW)));
endmodule

bind t0_char_rx t0rx_checker #(.TICKS_PER_ETU(TICKS_PER_ETU)) u_t0rx_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .tick           (tick),
    .cfg_chk_off    (cfg_chk_off),
    .cfg_sig_en     (cfg_sig_en),
    .cfg_t0         (cfg_t0),
    .cfg_drop_en    (cfg_drop_en),
    .clr_err        (clr_err),
    .line_drive_low (line_drive_low),
    .rx_valid       (rx_valid),
    .rx_perr        (rx_perr),
    .perr_sticky    (perr_sticky)
);

// File: tb/tb_t0_char_rx.sv
`timescale 1ns/1ps
module tb_t0_char_rx;
    localparam int N    = 16;
    localparam int HALF = N / 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b1;
    logic card_bit = 1'b1;
    logic cfg_chk_off = 1'b0, cfg_sig_en = 1'b0, cfg_t0 = 1'b1, cfg_drop_en = 1'b0;
    logic cfg_force_err = 1'b0, cfg_long_pulse = 1'b0, clr_err = 1'b0;
    logic line_drive_low, rx_valid, rx_perr, perr_sticky;
    logic [7:0] rx_data;
    wire  line_in = card_bit & ~line_drive_low;

    t0_char_rx #(.TICKS_PER_ETU(N)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .line_in(line_in),
        .cfg_chk_off(cfg_chk_off), .cfg_sig_en(cfg_sig_en), .cfg_t0(cfg_t0),
        .cfg_drop_en(cfg_drop_en), .cfg_force_err(cfg_force_err),
        .cfg_long_pulse(cfg_long_pulse), .clr_err(clr_err),
        .line_drive_low(line_drive_low), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_perr(rx_perr), .perr_sticky(perr_sticky)
    );

    always #2.5 clk = ~clk;

    int checks = 0, failures = 0;
    int cyc = 0;
    int n_valid, n_perr, low_len, first_low, n_pulses, start_cyc;
    logic [7:0] last_data;
    logic prev_low = 1'b0;
    logic exp_sticky = 1'b0;
    bit done = 1'b0;

    // monitor, 1 ns after each rising edge
    always begin
        @(posedge clk);
        #1;
        cyc++;
        if (rx_valid) begin n_valid++; last_data = rx_data; end
        if (rx_perr) n_perr++;
        if (line_drive_low) begin
            if (!prev_low) begin n_pulses++; first_low = cyc; end
            low_len++;
        end
        prev_low = line_drive_low;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic even_par(input logic [7:0] d);
        return ^d;
    endfunction

    task automatic send_char(input logic [7:0] d, input logic bad_par);
        logic [9:0] frame;
        frame = {even_par(d) ^ bad_par, d, 1'b0};
        @(negedge clk);
        n_valid = 0; n_perr = 0; low_len = 0; n_pulses = 0; first_low = 0;
        start_cyc = cyc;
        for (int i = 0; i < 10; i++) begin
            card_bit = frame[i];
            repeat (N) @(negedge clk);
        end
        card_bit = 1'b1;
        repeat (5 * N) @(negedge clk);
    endtask

    task automatic run_and_check(input logic [7:0] d, input logic bad_par, input string tag);
        logic e_perr, e_valid, e_pulse;
        int e_len, dt;
        e_perr  = !cfg_chk_off && (bad_par || cfg_force_err);
        e_valid = !(e_perr && cfg_drop_en);
        e_pulse = e_perr && cfg_sig_en && cfg_t0;
        e_len   = cfg_long_pulse ? 2 * N : N;
        send_char(d, bad_par);
        if (e_perr) exp_sticky = 1'b1;
        check(n_valid == int'(e_valid), {tag, " valid R1 R6"}, n_valid, int'(e_valid));
        if (e_valid) check(last_data == d, {tag, " data R1"}, last_data, d);
        check(n_perr == int'(e_perr), {tag, " perr R2 R3 R7"}, n_perr, int'(e_perr));
        check(n_pulses == int'(e_pulse), {tag, " pulse count R4 R5"}, n_pulses, int'(e_pulse));
        if (e_pulse) begin
            check(low_len >= e_len - 1 && low_len <= e_len + 1, {tag, " pulse length R4"}, low_len, e_len);
            dt = first_low - start_cyc;
            check(dt >= 10 * N + HALF && dt <= 10 * N + HALF + 6, {tag, " pulse start R4"}, dt, 10 * N + HALF + 4);
        end
        check(perr_sticky == exp_sticky, {tag, " sticky R8"}, perr_sticky, exp_sticky);
    endtask

    task automatic pulse_clear();
        @(negedge clk); clr_err = 1'b1;
        @(negedge clk); clr_err = 1'b0;
        exp_sticky = 1'b0;
        @(negedge clk);
        check(perr_sticky == 1'b0, "clear R8", perr_sticky, 0);
    endtask

    task automatic set_cfg(input logic off, input logic sig, input logic t0,
                           input logic drop, input logic force_e, input logic lng);
        cfg_chk_off = off; cfg_sig_en = sig; cfg_t0 = t0;
        cfg_drop_en = drop; cfg_force_err = force_e; cfg_long_pulse = lng;
    endtask

    initial begin
        void'($urandom(32'd7816));
        repeat (4) @(negedge clk);
        check(line_drive_low == 0 && rx_valid == 0 && rx_perr == 0 && perr_sticky == 0,
              "reset R10", {line_drive_low, rx_valid, rx_perr, perr_sticky}, 0);
        rst_n = 1'b1;
        repeat (3 * N) @(negedge clk);

        set_cfg(0, 0, 1, 0, 0, 0);
        run_and_check(8'hA5, 0, "good A5");
        run_and_check(8'h01, 0, "good 01 lsb-first");
        run_and_check(8'h80, 1, "bad 80 no signal R5");
        pulse_clear();
        set_cfg(0, 1, 1, 0, 0, 0);
        run_and_check(8'h3C, 0, "good no pulse R5");
        run_and_check(8'h3C, 1, "bad short pulse");
        set_cfg(0, 1, 1, 0, 0, 1);
        run_and_check(8'hC3, 1, "bad long pulse");
        set_cfg(0, 1, 0, 0, 0, 0);
        run_and_check(8'h55, 1, "bad t0 off R5");
        set_cfg(1, 1, 1, 1, 0, 0);
        run_and_check(8'h7E, 1, "check off R3");
        pulse_clear();
        set_cfg(1, 1, 1, 1, 1, 0);
        run_and_check(8'h7E, 0, "check off force R3");
        set_cfg(0, 0, 1, 1, 0, 0);
        run_and_check(8'hE1, 1, "drop R6");
        set_cfg(0, 0, 1, 0, 1, 0);
        run_and_check(8'h0F, 0, "force R7");

        // false start: short low glitch
        set_cfg(0, 1, 1, 0, 0, 0);
        @(negedge clk);
        n_valid = 0; n_perr = 0; n_pulses = 0;
        card_bit = 1'b0;
        repeat (3) @(negedge clk);
        card_bit = 1'b1;
        repeat (14 * N) @(negedge clk);
        check(n_valid == 0 && n_perr == 0 && n_pulses == 0, "false start R9",
              n_valid + n_perr + n_pulses, 0);
        run_and_check(8'h96, 0, "after glitch R9");

        for (int k = 0; k < 30; k++) begin
            set_cfg(($urandom % 4) == 0, $urandom % 2, ($urandom % 4) != 0,
                    $urandom % 2, ($urandom % 6) == 0, $urandom % 2);
            run_and_check(8'($urandom), ($urandom % 3) == 0, "random");
            if (($urandom % 5) == 0) pulse_clear();
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule